// File: doc/BRIEF.md
# Early-Terminating Slice Multiplier

This block multiplies two 64-bit unsigned operands and returns the full 128-bit product. It is iterative. Each working cycle it takes the next 10-bit slice of the second operand, multiplies the first operand by that slice, moves the partial product into place and adds it to an accumulator. The number of working cycles is fixed when the operation is accepted. It equals the number of slices up to and including the highest slice of the second operand that holds a set bit. Small second operands therefore finish sooner than wide ones.

The unit works on one operation at a time. A request is offered on `in_valid` with `in_a` and `in_b`, and it is taken on a clock edge where `in_ready` is also high. Back-pressure is simple. `in_ready` drops in the cycle after acceptance and stays low through the working cycles and the result cycle. While it is low, the input pins are ignored, and a source must hold its request until `in_ready` returns. The result has no back-pressure. `out_valid` is high for exactly one cycle, and `out_product` keeps that value until the next result replaces it.

Top module: `slice_mul`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `in_ready` is 1, `out_valid` is 0 and `out_product` is 0.
- R2: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle up to and including the cycle in which `out_valid` is 1.
- R3: The result presented with `out_valid` equals `in_a * in_b` of the accepted request, both treated as unsigned, as a 128-bit value.
- R4: Let slice k of `in_b` be bits [10k+9:10k] for k = 0 to 6; slice 6 holds only bits 63:60. Let n be one more than the highest k whose slice is non-zero, with n = 1 when `in_b` < 1024 (including 0). Call the acceptance cycle cycle 0. Then `out_valid` is 1 in cycle n+1 and in no other cycle of that operation.
- R5: A second operand with bit 63 set takes 7 slices, so its result appears in cycle 8. Counting inclusively from the acceptance cycle, the operation occupies 9 cycles. With requests waiting back to back, the next acceptance comes 9 cycles after the previous one.
- R6: `out_valid` is high for one cycle only. `out_product` does not change in any cycle where `out_valid` is 0.
- R7: While `in_ready` is 0, `in_valid`, `in_a` and `in_b` have no effect. No extra operation starts, and the result of the running one is not altered.
- R8: If either operand is zero, the product is zero, and the latency still follows R4 for the given `in_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_a | input | 64 | First operand, unsigned |
| in_b | input | 64 | Second operand, unsigned; its width sets the latency |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_product | output | 128 | Product, held until the next result |

## Verification
Several kinds of operand are used, and each one targets a different fault:

- **Zero and unit operands** show that an empty accumulator and a one-slice run are both handled.
- **All-ones operands** exercise the seven-slice worst case. Issued back to back, they expose an error in the busy window or in the restart spacing.
- **Single set bits on both sides of every 10-bit slice boundary** separate an off-by-one in the slice count from one in the placement of partial products.
- **Requests held valid during a busy run** show whether the inputs are ignored.
- **Random operands with random widths** cover the carry paths between slices.

For every operation, the bench compares the measured latency with the value it computes from the highest set bit of `in_b`.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } smul_state_e;

  function automatic int unsigned slices_for(int unsigned width, int unsigned slice_w);
    return (width + slice_w - 1) / slice_w;
  endfunction

endpackage

// File: rtl/smul_span.sv
// Works out how many slices of the second operand must be processed.
module smul_span #(
  parameter int B_W     = 64,
  parameter int SLICE_W = 10,
  parameter int NSLICE  = 7,
  parameter int CNT_W   = 3
) (
  input  logic [B_W-1:0]   b,
  output logic [CNT_W-1:0] n_slices
);
  localparam int PAD_W = NSLICE * SLICE_W;

  logic [PAD_W-1:0]  b_pad;
  logic [NSLICE-1:0] nz;

  assign b_pad = PAD_W'(b);

  for (genvar g = 0; g < NSLICE; g++) begin : g_nz
    assign nz[g] = |b_pad[g*SLICE_W +: SLICE_W];
  end

  // The highest non-zero slice wins; at least one slice is always run.
  always_comb begin
    n_slices = CNT_W'(1);
    for (int k = 0; k < NSLICE; k++) begin
      if (nz[k]) n_slices = CNT_W'(k + 1);
    end
  end
endmodule

// File: rtl/smul_step.sv
// One partial product: a times a slice, moved to the slice's bit offset.
module smul_step #(
  parameter int A_W     = 64,
  parameter int SLICE_W = 10,
  parameter int NSLICE  = 7,
  parameter int IDX_W   = 3,
  parameter int P_W     = 128
) (
  input  logic [A_W-1:0]     a,
  input  logic [SLICE_W-1:0] slice,
  input  logic [IDX_W-1:0]   idx,
  output logic [P_W-1:0]     term
);
  localparam int PP_W = A_W + SLICE_W;

  logic [PP_W-1:0] pp;
  logic [P_W-1:0]  placed [NSLICE];

  assign pp = PP_W'(a) * PP_W'(slice);

  for (genvar g = 0; g < NSLICE; g++) begin : g_place
    assign placed[g] = P_W'(pp) << (g * SLICE_W);
  end

  always_comb begin
    term = '0;
    for (int k = 0; k < NSLICE; k++) begin
      if (idx == IDX_W'(k)) term = placed[k];
    end
  end
endmodule

// File: rtl/smul_ctrl.sv
// Sequencer: idle / working / result states, and the slice counters.
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] n_load,
  output logic             in_ready,
  output logic             load,
  output logic             step,
  output logic             last,
  output logic [IDX_W-1:0] idx,
  output logic             out_valid
);
  smul_state_e      state;
  logic [CNT_W-1:0] left;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign load      = in_valid && (state == ST_IDLE);
  assign step      = (state == ST_RUN);
  assign last      = step && (left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      left  <= '0;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (load) begin
            state <= ST_RUN;
            left  <= n_load;
            idx   <= '0;
          end
        end
        ST_RUN: begin
          left <= left - CNT_W'(1);
          idx  <= idx + IDX_W'(1);
          if (last) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slice_mul.sv
// Iterative unsigned multiplier whose run length tracks the width of in_b.
module slice_mul #(
  parameter  int A_W     = 64,
  parameter  int B_W     = 64,
  parameter  int SLICE_W = 10,
  localparam int P_W     = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [A_W-1:0] in_a,
  input  logic [B_W-1:0] in_b,
  output logic           out_valid,
  output logic [P_W-1:0] out_product
);
  localparam int NSLICE = smul_pkg::slices_for(B_W, SLICE_W);
  localparam int CNT_W  = $clog2(NSLICE + 1);
  localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1;

  logic [CNT_W-1:0] n_load;
  logic             load, step, last;
  logic [IDX_W-1:0] idx;

  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_rem;
  logic [P_W-1:0]   acc;
  logic [P_W-1:0]   term;
  logic [P_W-1:0]   sum;
  logic [P_W-1:0]   prod_q;

  smul_span #(
    .B_W(B_W), .SLICE_W(SLICE_W), .NSLICE(NSLICE), .CNT_W(CNT_W)
  ) u_span (
    .b        (in_b),
    .n_slices (n_load)
  );

  smul_ctrl #(
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .n_load    (n_load),
    .in_ready  (in_ready),
    .load      (load),
    .step      (step),
    .last      (last),
    .idx       (idx),
    .out_valid (out_valid)
  );

  smul_step #(
    .A_W(A_W), .SLICE_W(SLICE_W), .NSLICE(NSLICE), .IDX_W(IDX_W), .P_W(P_W)
  ) u_step (
    .a     (a_q),
    .slice (b_rem[SLICE_W-1:0]),
    .idx   (idx),
    .term  (term)
  );

  assign sum = acc + term;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_rem  <= '0;
      acc    <= '0;
      prod_q <= '0;
    end else if (load) begin
      a_q   <= in_a;
      b_rem <= in_b;
      acc   <= '0;
    end else if (step) begin
      acc   <= sum;
      b_rem <= b_rem >> SLICE_W;
      if (last) prod_q <= sum;
    end
  end

  assign out_product = prod_q;
endmodule

// File: rtl/smul_chk.sv
// Port-level checker attached to every slice_mul instance.
module smul_chk #(
  parameter  int A_W     = 64,
  parameter  int B_W     = 64,
  parameter  int SLICE_W = 10,
  localparam int P_W     = A_W + B_W
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [A_W-1:0] in_a,
  input logic [B_W-1:0] in_b,
  input logic           out_valid,
  input logic [P_W-1:0] out_product
);
  localparam int NSLICE = (B_W + SLICE_W - 1) / SLICE_W;
  localparam int MAXLAT = NSLICE + 1;

  logic           busy;
  logic           armed;
  int unsigned    age;
  logic [A_W-1:0] cap_a;
  logic [B_W-1:0] cap_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      armed <= 1'b0;
      age   <= 0;
      cap_a <= '0;
      cap_b <= '0;
    end else begin
      armed <= 1'b1;
      if (in_valid && in_ready) begin
        busy  <= 1'b1;
        age   <= 1;
        cap_a <= in_a;
        cap_b <= in_b;
      end else if (out_valid) begin
        busy <= 1'b0;
      end else if (busy) begin
        age <= age + 1;
      end
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready); // R2

  AST_RESULT_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy); // R7

  AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_product == P_W'(cap_a) * P_W'(cap_b))); // R3

  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (age >= 2 && age <= MAXLAT)); // R5

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R6

  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (rst || !armed)
    !out_valid |-> $stable(out_product)); // R6

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (cap_a == '0 || cap_b == '0)) |-> (out_product == '0)); // R8
endmodule

bind slice_mul smul_chk #(.A_W(A_W), .B_W(B_W), .SLICE_W(SLICE_W)) u_chk (.*);

// File: tb/tb_slice_mul.sv
module tb_slice_mul;
  localparam int A_W = 64;
  localparam int B_W = 64;
  localparam int SW  = 10;
  localparam int P_W = A_W + B_W;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [A_W-1:0] in_a = '0;
  logic [B_W-1:0] in_b = '0;
  logic           in_ready;
  logic           out_valid;
  logic [P_W-1:0] out_product;

  slice_mul dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_product(out_product)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [P_W-1:0] prod;
    int             lat;
    int             acc_edge;
    string          tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sent = 0;
  int results = 0;
  int last_acc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [P_W-1:0] act, input logic [P_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Slice count from the highest set bit of b; at least one slice.
  function automatic int exp_slices(input logic [B_W-1:0] b);
    int n = 1;
    for (int k = 0; k < B_W; k++) if (b[k]) n = k / SW + 1;
    return n;
  endfunction

  // Driver: waits for ready, offers one request, records the expectation.
  // noise > 0 keeps in_valid high with other operands while the unit is busy.
  task automatic send(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                      input string tag, input int noise);
    item_t it;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    it.prod = P_W'(a) * P_W'(b);
    it.lat = exp_slices(b) + 1;
    it.acc_edge = cyc + 1;
    it.tag = tag;
    last_acc = cyc + 1;
    sb.push_back(it);
    sent++;
    @(negedge clk);
    if (noise > 0) begin
      in_a = ~a;
      in_b = ~b;
      repeat (noise) @(negedge clk);
    end
    in_valid = 1'b0;
    in_a = '0;
    in_b = '0;
  endtask

  // Monitor: pops the scoreboard on every result pulse.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      results++;
      if (sb.size() == 0) begin
        check(1'b0, "R7", "result with no accepted request", out_product, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(out_product == it.prod, it.tag, "product", out_product, it.prod);
        check((cyc - it.acc_edge + 1) == it.lat, "R4", "latency",
              P_W'(cyc - it.acc_edge + 1), P_W'(it.lat));
        check(!in_ready, "R2", "ready during result cycle", P_W'(in_ready), '0);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", results, sent);
    finish_run();
  end

  initial begin
    logic [A_W-1:0] ra;
    logic [B_W-1:0] rb;
    logic [P_W-1:0] held;
    int acc1;

    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready in reset", P_W'(in_ready), P_W'(1));
    check(out_valid == 1'b0, "R1", "valid in reset", P_W'(out_valid), '0);
    check(out_product == '0, "R1", "product in reset", out_product, '0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && out_product == '0, "R1",
          "state after reset", out_product, '0);

    // Zero operands
    send('0, '0, "R8", 0);
    send(64'd12345, '0, "R8", 0);
    send('0, '1, "R8", 0);
    // Unit and full-width operands
    send(64'd1, 64'd1, "R3", 0);
    send('1, '1, "R3", 0);
    send('1, 64'd1, "R3", 0);

    // Single set bits on each side of every slice boundary
    for (int k = 0; k < B_W; k++) begin
      if ((k % SW) == 0 || (k % SW) == SW - 1 || k == B_W - 1) begin
        ra = {$urandom(), $urandom()};
        send(ra, B_W'(1) << k, "R3", 0);
      end
    end

    // Back-to-back worst case: restart spacing
    send('1, '1, "R5", 0);
    acc1 = last_acc;
    send('1, 64'h8000_0000_0000_0001, "R5", 0);
    check((last_acc - acc1) == 9, "R5", "accept spacing",
          P_W'(last_acc - acc1), P_W'(9));

    // Requests held valid while busy must be ignored
    send(64'h0123_4567_89ab_cdef, 64'h0000_0100_0000_0003, "R7", 2);
    send(64'hdead_beef_0000_0001, '1, "R7", 3);

    // Random operands of random width
    for (int i = 0; i < 40; i++) begin
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      rb = rb >> ($urandom() % 64);
      send(ra, rb, "R3", 0);
    end

    // Pulse width and hold of the result
    send(64'hffff_0000_ffff_0000, 64'h3ff_ffff, "R6", 0);
    do @(negedge clk); while (!out_valid);
    held = out_product;
    check(held == P_W'(64'hffff_0000_ffff_0000) * P_W'(64'h3ff_ffff), "R6",
          "value held", held, P_W'(64'hffff_0000_ffff_0000) * P_W'(64'h3ff_ffff));
    repeat (5) begin
      @(negedge clk);
      check(out_valid == 1'b0 && out_product == held, "R6", "hold after pulse",
            out_product, held);
    end

    repeat (20) @(negedge clk);
    check(sb.size() == 0 && results == sent, "R7", "result count",
          P_W'(results), P_W'(sent));
    finish_run();
  end
endmodule